// File: doc/BRIEF.md
# Bus Output Drive and Float Controller

This block decides, cycle by cycle, which groups of a processor-style external bus are actively driven and which are released to high impedance. It also produces the write/read direction level for each bus cycle and the hold-acknowledge handshake. The surrounding bus unit reports the start of each cycle, the pipelining request, the ready responses and whether a ready is the final one. The system side supplies the back-off, address-hold and bus-hold requests and a test control that floats the whole part.

Each pin group has its own float rule. The control group and the data bus are released on back-off and on hold acknowledge. The address lines and their parity are also released while an external agent holds the address bus. A group of status pins stays driven in all cases except test float. The two core-voltage detect levels are constant zero and are never released. Every enable is registered, so it changes only at a rising clock edge.

The controller state machine has four states. `ST_IDLE`: no cycle is outstanding. `ST_XFER`: a cycle is running and the direction level is held. `ST_PIPE`: a pipelining request has released the direction level, but the final ready is still pending. `ST_GRANT`: hold is acknowledged. The transitions are:
- `ST_IDLE`→`ST_XFER` on a cycle start.
- `ST_IDLE`→`ST_GRANT` on a hold request with no start.
- `ST_XFER`→`ST_PIPE` on a pipelining request without the final ready.
- `ST_XFER`→`ST_IDLE` on the final ready.
- `ST_PIPE`→`ST_XFER` on a new cycle start.
- `ST_PIPE`→`ST_IDLE` on the final ready with no new start.
- `ST_GRANT`→`ST_IDLE` when hold is sampled negated.

Top module: `bus_drive_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is idle: hold_ack is 0, wr_level is 0 and every enable output is 1.
- R2: In a cycle where cyc_start_n is 0 and the state is idle or pipelined, wr_level equals cyc_write in that same cycle (1 = write, 0 = read).
- R3: While a cycle is in the held state (ST_XFER), wr_level keeps the value captured at the start. It changes at the earliest in the cycle after the edge where pipe_adv_n is sampled 0, or where rdy_n is sampled 0 with last_xfer 1.
- R4: After every edge where backoff_n is sampled 0, or where hold_ack becomes 1, en_ctrl and every bit of en_data and en_data_par are 0. Otherwise, outside test float, they are 1.
- R5: en_addr_hi, en_addr_lo and en_addr_par follow R4 and are also 0 after every edge where addr_hold is sampled 1. addr_hold has no effect on en_ctrl, en_data or en_data_par.
- R6: hold_ack rises only at an edge where hold_req is 1, the state is idle and cyc_start_n is 1. A start sampled in the same cycle as a hold request takes priority. A hold request made during an outstanding cycle waits until the cycle completes.
- R7: hold_ack falls at the first edge where hold_req is sampled 0.
- R8: While hold_ack is 1, cyc_start_n is ignored: wr_level does not change and no cycle begins.
- R9: After every edge where tst_float is sampled 1, every enable output, en_status included, is 0. core_det_lvl is always 2'b00.
- R10: en_status is 1 after every edge where tst_float is sampled 0, whatever back-off, address hold or bus hold are doing.
- R11: All DATA_LANES bits of en_data and of en_data_par always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start_n | input | 1 | Cycle-start strobe, active low |
| cyc_write | input | 1 | Direction of the starting cycle, 1 = write |
| pipe_adv_n | input | 1 | Pipelining request, active low |
| rdy_n | input | 1 | Transfer ready, active low |
| last_xfer | input | 1 | Marks the current ready as the final one of the cycle |
| backoff_n | input | 1 | Back-off request, active low |
| addr_hold | input | 1 | External address-hold request |
| hold_req | input | 1 | Bus hold request |
| tst_float | input | 1 | Test control that floats all releasable outputs |
| wr_level | output | 1 | Write/read level, 1 = write |
| hold_ack | output | 1 | Hold acknowledge |
| en_ctrl | output | 1 | Drive enable for the control group |
| en_addr_hi | output | 1 | Drive enable for the upper address lines |
| en_addr_lo | output | 1 | Drive enable for the lower address lines |
| en_addr_par | output | 1 | Drive enable for address parity |
| en_data | output | DATA_LANES | Per-lane drive enable for the data bus |
| en_data_par | output | DATA_LANES | Per-lane drive enable for data parity |
| en_status | output | 1 | Drive enable for the always-driven status pins |
| core_det_lvl | output | 2 | Core-voltage detect levels, constant 0 |

## Verification
The bench builds the block with DATA_LANES set to 4 rather than the default 8. This exercises the lane generate loop at a width other than the default, while the per-lane agreement of R11 is still checked on every bit. Random traffic uses sustained hold bursts, rare test-float pulses and frequent address holds. With that mix, hold requests arrive during outstanding and pipelined cycles, back-off overlaps with grant, and address hold overlaps with a running cycle. Directed sequences add a start coinciding with a hold request and an isolated test-float pulse.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_PIPE  = 2'd2,
        ST_GRANT = 2'd3
    } bus_state_e;
endpackage

// File: rtl/bdc_cycle_fsm.sv
module bdc_cycle_fsm
    import bdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pipe_i,
    input  logic       final_rdy_i,
    input  logic       hold_i,
    output bus_state_e state_o,
    output logic       start_ok_o,
    output logic       grant_nxt_o,
    output logic       hold_ack_o
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)     state_d = ST_XFER;
                else if (hold_i) state_d = ST_GRANT;
            end
            ST_XFER: begin
                if (final_rdy_i) state_d = ST_IDLE;
                else if (pipe_i) state_d = ST_PIPE;
            end
            ST_PIPE: begin
                if (start_i)          state_d = ST_XFER;
                else if (final_rdy_i) state_d = ST_IDLE;
            end
            ST_GRANT: begin
                if (!hold_i) state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        state_o     = state_q;
        start_ok_o  = start_i && (state_q == ST_IDLE || state_q == ST_PIPE);
        grant_nxt_o = (state_d == ST_GRANT);
        hold_ack_o  = (state_q == ST_GRANT);
    end

    // R6
    grant_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_o) |-> ($past(state_q) == ST_IDLE) && $past(hold_i) && !$past(start_i));

    // R7
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack_o && !hold_i) |=> !hold_ack_o);
endmodule

// File: rtl/bdc_wr_hold.sv
module bdc_wr_hold
    import bdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_e state_i,
    input  logic       start_ok_i,
    input  logic       write_i,
    output logic       wr_o
);
    logic wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wr_q <= 1'b0;
        else if (start_ok_i) wr_q <= write_i;
    end

    always_comb wr_o = start_ok_i ? write_i : wr_q;

    // R3
    wr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_XFER) |-> $stable(wr_o));

    // R8
    wr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_GRANT && $past(state_i) == ST_GRANT) |-> $stable(wr_o));
endmodule

// File: rtl/bdc_enable_reg.sv
module bdc_enable_reg #(
    parameter int DATA_LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tst_i,
    input  logic                  boff_i,
    input  logic                  ahold_i,
    input  logic                  grant_nxt_i,
    output logic                  en_ctrl_o,
    output logic                  en_addr_hi_o,
    output logic                  en_addr_lo_o,
    output logic                  en_addr_par_o,
    output logic [DATA_LANES-1:0] en_data_o,
    output logic [DATA_LANES-1:0] en_data_par_o,
    output logic                  en_status_o
);
    localparam logic [DATA_LANES-1:0] ALL_ON = '1;

    logic release_bus;
    logic release_addr;

    always_comb begin
        release_bus  = tst_i || boff_i || grant_nxt_i;
        release_addr = release_bus || ahold_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_ctrl_o     <= 1'b1;
            en_addr_hi_o  <= 1'b1;
            en_addr_lo_o  <= 1'b1;
            en_addr_par_o <= 1'b1;
            en_status_o   <= 1'b1;
        end else begin
            en_ctrl_o     <= !release_bus;
            en_addr_hi_o  <= !release_addr;
            en_addr_lo_o  <= !release_addr;
            en_addr_par_o <= !release_addr;
            en_status_o   <= !tst_i;
        end
    end

    for (genvar g = 0; g < DATA_LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_data_o[g]     <= 1'b1;
                en_data_par_o[g] <= 1'b1;
            end else begin
                en_data_o[g]     <= !release_bus;
                en_data_par_o[g] <= !release_bus;
            end
        end
    end

    // R4
    backoff_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boff_i |=> (!en_ctrl_o && en_data_o == '0 && en_data_par_o == '0));

    // R5
    ahold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ahold_i |=> (!en_addr_hi_o && !en_addr_lo_o && !en_addr_par_o));

    // R9
    test_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_i |=> (!en_status_o && !en_ctrl_o && !en_addr_hi_o));

    // R11
    lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_data_o == '0 || en_data_o == ALL_ON) && (en_data_par_o == en_data_o));
endmodule

// File: rtl/bus_drive_ctrl.sv
module bus_drive_ctrl
    import bdc_pkg::*;
#(
    parameter int DATA_LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_start_n,
    input  logic                  cyc_write,
    input  logic                  pipe_adv_n,
    input  logic                  rdy_n,
    input  logic                  last_xfer,
    input  logic                  backoff_n,
    input  logic                  addr_hold,
    input  logic                  hold_req,
    input  logic                  tst_float,
    output logic                  wr_level,
    output logic                  hold_ack,
    output logic                  en_ctrl,
    output logic                  en_addr_hi,
    output logic                  en_addr_lo,
    output logic                  en_addr_par,
    output logic [DATA_LANES-1:0] en_data,
    output logic [DATA_LANES-1:0] en_data_par,
    output logic                  en_status,
    output logic [1:0]            core_det_lvl
);
    bus_state_e state;
    logic       start_ok;
    logic       grant_nxt;

    bdc_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (!cyc_start_n),
        .pipe_i      (!pipe_adv_n),
        .final_rdy_i (!rdy_n && last_xfer),
        .hold_i      (hold_req),
        .state_o     (state),
        .start_ok_o  (start_ok),
        .grant_nxt_o (grant_nxt),
        .hold_ack_o  (hold_ack)
    );

    bdc_wr_hold u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .start_ok_i (start_ok),
        .write_i    (cyc_write),
        .wr_o       (wr_level)
    );

    bdc_enable_reg #(.DATA_LANES(DATA_LANES)) u_en (
        .clk           (clk),
        .rst_n         (rst_n),
        .tst_i         (tst_float),
        .boff_i        (!backoff_n),
        .ahold_i       (addr_hold),
        .grant_nxt_i   (grant_nxt),
        .en_ctrl_o     (en_ctrl),
        .en_addr_hi_o  (en_addr_hi),
        .en_addr_lo_o  (en_addr_lo),
        .en_addr_par_o (en_addr_par),
        .en_data_o     (en_data),
        .en_data_par_o (en_data_par),
        .en_status_o   (en_status)
    );

    assign core_det_lvl = 2'b00;

    // R10
    status_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tst_float) |=> en_status);

    // R8
    no_start_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && hold_req) |=> hold_ack);
endmodule

// File: tb/test_bus_drive_ctrl.sv
module test_bus_drive_ctrl;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start_n = 1'b1, cyc_write = 1'b0, pipe_adv_n = 1'b1, rdy_n = 1'b1;
    logic last_xfer = 1'b0, backoff_n = 1'b1, addr_hold = 1'b0, hold_req = 1'b0;
    logic tst_float = 1'b0;
    logic wr_level, hold_ack, en_ctrl, en_addr_hi, en_addr_lo, en_addr_par, en_status;
    logic [LANES-1:0] en_data, en_data_par;
    logic [1:0] core_det_lvl;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state: 0 idle, 1 held cycle, 2 pipelined, 3 granted
    int  m_st = 0;
    bit  m_wr = 1'b0;
    bit  m_bus_on = 1'b1, m_addr_on = 1'b1, m_stat_on = 1'b1;

    always #10 clk = ~clk;

    bus_drive_ctrl #(.DATA_LANES(LANES)) i_bus_drive_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_start_n(cyc_start_n), .cyc_write(cyc_write),
        .pipe_adv_n(pipe_adv_n), .rdy_n(rdy_n), .last_xfer(last_xfer),
        .backoff_n(backoff_n), .addr_hold(addr_hold), .hold_req(hold_req),
        .tst_float(tst_float), .wr_level(wr_level), .hold_ack(hold_ack),
        .en_ctrl(en_ctrl), .en_addr_hi(en_addr_hi), .en_addr_lo(en_addr_lo),
        .en_addr_par(en_addr_par), .en_data(en_data), .en_data_par(en_data_par),
        .en_status(en_status), .core_det_lvl(core_det_lvl)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int next_state(int st, bit s, bit na, bit fin, bit h);
        case (st)
            0: return s ? 1 : (h ? 3 : 0);
            1: return fin ? 0 : (na ? 2 : 1);
            2: return s ? 1 : (fin ? 0 : 2);
            default: return h ? 3 : 0;
        endcase
    endfunction

    task automatic check_regs(input string tag);
        chk({tag, " R6 R7"}, "hold_ack", hold_ack, m_st == 3);
        chk({tag, " R4"}, "en_ctrl", en_ctrl, m_bus_on);
        chk({tag, " R5"}, "en_addr", {en_addr_hi, en_addr_lo, en_addr_par},
            {3{m_addr_on}});
        chk({tag, " R11"}, "en_data", en_data, {LANES{m_bus_on}});
        chk({tag, " R11"}, "en_data_par", en_data_par, {LANES{m_bus_on}});
        chk({tag, " R10"}, "en_status", en_status, m_stat_on);
        chk({tag, " R9"}, "core_det_lvl", core_det_lvl, 2'b00);
    endtask

    // called at a falling edge: drive, check direction level, clock, check registers
    task automatic step(input bit s, input bit w, input bit na, input bit rdy,
                        input bit lst, input bit boff, input bit ah, input bit h,
                        input bit t);
        bit can_start;
        bit exp_wr;
        int nst;
        cyc_start_n = !s; cyc_write = w; pipe_adv_n = !na; rdy_n = !rdy;
        last_xfer = lst; backoff_n = !boff; addr_hold = ah; hold_req = h;
        tst_float = t;
        #1;
        can_start = s && (m_st == 0 || m_st == 2);
        exp_wr = can_start ? w : m_wr;
        if (can_start)      chk("R2", "wr_level", wr_level, exp_wr);
        else if (m_st == 3) chk("R8", "wr_level", wr_level, exp_wr);
        else                chk("R3", "wr_level", wr_level, exp_wr);
        @(posedge clk);
        nst = next_state(m_st, s, na, rdy && lst, h);
        m_wr = exp_wr;
        m_bus_on = !(t || boff || nst == 3);
        m_addr_on = m_bus_on && !ah;
        m_stat_on = !t;
        m_st = nst;
        @(negedge clk);
        check_regs("");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit hold_r;
        void'($urandom(32'd1234));
        hold_r = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "hold_ack in reset", hold_ack, 1'b0);
        chk("R1", "wr_level in reset", wr_level, 1'b0);
        chk("R1", "enables in reset",
            {en_ctrl, en_addr_hi, en_addr_lo, en_addr_par, en_status, en_data, en_data_par},
            {(5 + 2 * LANES){1'b1}});
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1");

        // directed: write cycle, stray direction change ignored, final ready
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);   // hold waits during a cycle (R6)
        step(0, 0, 0, 1, 1, 0, 0, 1, 0);   // final ready
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);   // grant now
        step(1, 0, 0, 0, 0, 0, 0, 1, 0);   // start ignored in grant (R8)
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);   // release (R7)
        // start and hold together: start wins (R6)
        step(1, 0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0, 0);   // pipelining request
        step(1, 1, 0, 1, 1, 0, 0, 0, 0);   // new start in pipelined state
        step(0, 0, 0, 1, 1, 0, 1, 0, 0);   // address hold only (R5)
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);   // back-off (R4)
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);   // test float (R9)
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(9) == 0) hold_r = !hold_r;
            step($urandom_range(2) == 0, $urandom_range(1) == 1,
                 $urandom_range(3) == 0, $urandom_range(1) == 1,
                 $urandom_range(1) == 1, $urandom_range(9) == 0,
                 $urandom_range(5) == 0, hold_r, $urandom_range(19) == 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule